// File: doc/BRIEF.md
# SPI NOR Flash Command Sequencer

This block turns one-word host requests into complete SPI mode-0 transactions for a NOR serial flash. A request names one of seven operations: identify, status read, write enable, whole-array erase, 4 KB sector erase, data read and page program. It may also carry a 24-bit byte address and a byte count. The engine lowers chip select, shifts out the opcode, and then sends the address when the operation needs one. After that it either streams data bytes or, for the operations that start an internal flash cycle, repeatedly issues separate status-read transactions until that operation's own completion condition is met.

Read data is handed to the host one byte at a time with a one-cycle valid strobe. Program data is pulled through a valid/ready pair, and the engine holds chip select low with SCLK parked while the host has nothing to offer. A programmable SCLK divider sets the serial rate, and a programmable poll limit bounds how long a status wait may last. Each operation ends with a one-cycle completion pulse. If the request was malformed or the wait timed out, an error flag is raised alongside that pulse.

Top module: `sflash_cmd_engine`

## Requirements
- R1: After reset, cs_n is high, sclk is low, and busy, done and err are all low.
- R2: SCLK idles low. Every byte is shifted MSB first, and MOSI changes only while SCLK is low. MISO is captured when SCLK rises. The SCLK high phase and the low phase each last max(half_div,1) clock cycles.
- R3: req_cmd 0 (identify) sends 0x9F, then clocks in exactly 3 bytes, each presented on rd_data with a one-cycle rd_valid.
- R4: req_cmd 1 (status read) sends 0x05 and returns the single status byte on rd_data. In that byte, bit 0 is busy and bit 1 is write-enabled.
- R5: req_cmd 2 (write enable) sends 0x06, then polls status until bit 1 reads 1.
- R6: req_cmd 3 (whole-array erase) sends 0xC7, then polls status until bit 0 reads 0.
- R7: req_cmd 4 (sector erase) sends 0x20 followed by the 24-bit address, most significant byte first. It then polls status until bit 0 reads 0.
- R8: req_cmd 5 (read) sends 0x03 and the 24-bit address, then returns req_len bytes on rd_data.
- R9: req_cmd 6 (page program) sends 0x02 and the address, then transfers req_len bytes. Each byte is taken on a cycle where wr_valid and wr_ready are both high. While no byte is offered, cs_n stays low.
- R10: A page program whose req_len is 0 or greater than 255 is rejected, and so is req_cmd 7. A rejected request gives done and err together and never lowers cs_n.
- R11: cs_n stays low for the whole of one transaction. Before every status poll, cs_n is high for at least 2 clock cycles.
- R12: If poll_limit consecutive polls fail the completion condition, the operation ends with done and err. A poll_limit of 0 behaves as 1.
- R13: busy is high from the cycle after acceptance until done. done is a one-cycle pulse that coincides with busy going low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| half_div | input | DIV_W | System clocks per SCLK half period (0 treated as 1) |
| poll_limit | input | POLL_W | Maximum status polls before timeout (0 treated as 1) |
| req_valid | input | 1 | Request strobe, accepted while busy is low |
| req_cmd | input | 3 | Operation code |
| req_addr | input | 24 | Flash byte address |
| req_len | input | LEN_W | Byte count for read and page program |
| wr_data | input | 8 | Program data byte |
| wr_valid | input | 1 | Program data available |
| wr_ready | output | 1 | Engine waiting for a program byte |
| rd_data | output | 8 | Received data byte |
| rd_valid | output | 1 | rd_data valid for one cycle |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Operation finished (one cycle) |
| err | output | 1 | Last operation rejected or timed out |
| sclk | output | 1 | SPI serial clock |
| cs_n | output | 1 | SPI chip select, active low |
| mosi | output | 1 | SPI data to flash |
| miso | input | 1 | SPI data from flash |

## Verification
The hardest behaviour to reach from the ports is the status-wait loop: the exit path for each command, the timeout exit, and the chip-select gap between polls. The bench therefore attaches a behavioural flash whose status register misbehaves in controlled ways. Its write-enable bit appears only after a set number of status reads, and its busy bit stays set for a set number of reads after an erase. This lets the bench predict the exact poll count for each exit path. A timeout is forced by making the busy count exceed poll_limit. Program-data back-pressure is produced by withholding wr_valid until the header has finished.

// File: rtl/sfe_pkg.sv
`timescale 1ns/1ps
package sfe_pkg;
   typedef enum logic [2:0] {
      OP_RDID  = 3'd0,
      OP_RDSR  = 3'd1,
      OP_WREN  = 3'd2,
      OP_CHER  = 3'd3,
      OP_SECER = 3'd4,
      OP_READ  = 3'd5,
      OP_PROG  = 3'd6,
      OP_BAD   = 3'd7
   } sfe_op_e;

   localparam logic [7:0] SR_OPC   = 8'h05;
   localparam int         SR_BUSY  = 0;
   localparam int         SR_WEL   = 1;
   localparam int         ID_BYTES = 3;
   localparam int         MAX_PROG = 255;

   function automatic logic [7:0] sfe_opcode(sfe_op_e c);
      case (c)
         OP_RDID:  return 8'h9F;
         OP_RDSR:  return 8'h05;
         OP_WREN:  return 8'h06;
         OP_CHER:  return 8'hC7;
         OP_SECER: return 8'h20;
         OP_READ:  return 8'h03;
         OP_PROG:  return 8'h02;
         default:  return 8'h00;
      endcase
   endfunction
endpackage

// File: rtl/sfe_byte_shift.sv
`timescale 1ns/1ps
module sfe_byte_shift #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] half_div,
   input  logic             start,
   input  logic [7:0]       tx_byte,
   input  logic             miso,
   output logic             sclk,
   output logic             mosi,
   output logic [7:0]       rx_byte,
   output logic             byte_done
);
   logic [DIV_W-1:0] dcnt;
   logic [DIV_W-1:0] lim;
   logic [2:0]       bitn;
   logic [7:0]       txs;
   logic [7:0]       rxs;
   logic             run;
   logic             sck;

   assign lim = (half_div == '0) ? DIV_W'(1) : half_div;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dcnt      <= '0;
         bitn      <= '0;
         txs       <= '0;
         rxs       <= '0;
         run       <= 1'b0;
         sck       <= 1'b0;
         byte_done <= 1'b0;
      end else begin
         byte_done <= 1'b0;
         if (start && !run) begin
            run  <= 1'b1;
            txs  <= tx_byte;
            bitn <= '0;
            dcnt <= '0;
            sck  <= 1'b0;
         end else if (run) begin
            if (dcnt == lim - 1'b1) begin
               dcnt <= '0;
               sck  <= ~sck;
               if (!sck) begin
                  rxs <= {rxs[6:0], miso};
               end else if (bitn == 3'd7) begin
                  run       <= 1'b0;
                  byte_done <= 1'b1;
               end else begin
                  bitn <= bitn + 3'd1;
                  txs  <= {txs[6:0], 1'b0};
               end
            end else begin
               dcnt <= dcnt + 1'b1;
            end
         end
      end
   end

   assign sclk    = sck;
   assign mosi    = txs[7];
   assign rx_byte = rxs;

   // R2: data toward the flash is settled before SCLK rises
   a_r2_mosi_stable: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sclk) |-> $stable(mosi));
endmodule

// File: rtl/sfe_seq.sv
`timescale 1ns/1ps
module sfe_seq
   import sfe_pkg::*;
#(
   parameter int LEN_W   = 9,
   parameter int POLL_W  = 16,
   parameter int GAP_CYC = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [2:0]        req_cmd,
   input  logic [23:0]       req_addr,
   input  logic [LEN_W-1:0]  req_len,
   input  logic [POLL_W-1:0] poll_limit,
   input  logic [7:0]        wr_data,
   input  logic              wr_valid,
   output logic              wr_ready,
   output logic [7:0]        rd_data,
   output logic              rd_valid,
   output logic              busy,
   output logic              done,
   output logic              err,
   output logic              cs_n,
   output logic              sh_start,
   output logic [7:0]        sh_tx,
   input  logic              sh_done,
   input  logic [7:0]        sh_rx
);
   localparam int GW = $clog2(GAP_CYC + 1);

   typedef enum logic [2:0] {
      S_IDLE, S_HDR, S_RD, S_WAITW, S_WR, S_GAP, S_POLLOP, S_POLLRD
   } st_e;

   st_e               st;
   sfe_op_e           op;
   logic [23:0]       addr;
   logic [LEN_W-1:0]  left;
   logic [1:0]        hidx;
   logic [POLL_W-1:0] pcnt;
   logic [GW-1:0]     gcnt;

   sfe_op_e           cmd_in;
   logic              has_addr, hdr_last, polls, poll_ok, bad_req;
   logic [1:0]        hnext;
   logic [7:0]        abyte;
   logic [POLL_W-1:0] plim;

   assign cmd_in   = sfe_op_e'(req_cmd);
   assign has_addr = (op == OP_SECER) || (op == OP_READ) || (op == OP_PROG);
   assign hdr_last = has_addr ? (hidx == 2'd3) : 1'b1;
   assign polls    = (op == OP_WREN) || (op == OP_CHER) || (op == OP_SECER);
   assign poll_ok  = (op == OP_WREN) ? sh_rx[SR_WEL] : !sh_rx[SR_BUSY];
   assign hnext    = hidx + 2'd1;
   assign bad_req  = (cmd_in == OP_BAD) ||
                     ((cmd_in == OP_PROG) &&
                      ((req_len == '0) || (req_len > LEN_W'(MAX_PROG))));
   assign plim     = (poll_limit == '0) ? POLL_W'(1) : poll_limit;

   always_comb begin
      case (hnext)
         2'd1:    abyte = addr[23:16];
         2'd2:    abyte = addr[15:8];
         default: abyte = addr[7:0];
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= S_IDLE;
         op       <= OP_RDID;
         addr     <= '0;
         left     <= '0;
         hidx     <= '0;
         pcnt     <= '0;
         gcnt     <= '0;
         cs_n     <= 1'b1;
         sh_start <= 1'b0;
         sh_tx    <= '0;
         rd_data  <= '0;
         rd_valid <= 1'b0;
         done     <= 1'b0;
         err      <= 1'b0;
      end else begin
         sh_start <= 1'b0;
         rd_valid <= 1'b0;
         done     <= 1'b0;
         case (st)
            S_IDLE: if (req_valid) begin
               op   <= cmd_in;
               addr <= req_addr;
               left <= req_len;
               hidx <= '0;
               pcnt <= '0;
               err  <= 1'b0;
               if (bad_req) begin
                  err  <= 1'b1;
                  done <= 1'b1;
               end else begin
                  cs_n     <= 1'b0;
                  sh_tx    <= sfe_opcode(cmd_in);
                  sh_start <= 1'b1;
                  st       <= S_HDR;
               end
            end
            S_HDR: if (sh_done) begin
               if (!hdr_last) begin
                  hidx     <= hnext;
                  sh_tx    <= abyte;
                  sh_start <= 1'b1;
               end else if (polls) begin
                  cs_n <= 1'b1;
                  gcnt <= '0;
                  st   <= S_GAP;
               end else if (op == OP_PROG) begin
                  st <= S_WAITW;
               end else if ((op == OP_RDID) || (op == OP_RDSR) || (left != '0)) begin
                  if (op == OP_RDID)      left <= LEN_W'(ID_BYTES);
                  else if (op == OP_RDSR) left <= LEN_W'(1);
                  sh_tx    <= '0;
                  sh_start <= 1'b1;
                  st       <= S_RD;
               end else begin
                  cs_n <= 1'b1;
                  done <= 1'b1;
                  st   <= S_IDLE;
               end
            end
            S_RD: if (sh_done) begin
               rd_data  <= sh_rx;
               rd_valid <= 1'b1;
               if (left == LEN_W'(1)) begin
                  cs_n <= 1'b1;
                  done <= 1'b1;
                  st   <= S_IDLE;
               end else begin
                  left     <= left - 1'b1;
                  sh_start <= 1'b1;
               end
            end
            S_WAITW: if (wr_valid) begin
               sh_tx    <= wr_data;
               sh_start <= 1'b1;
               st       <= S_WR;
            end
            S_WR: if (sh_done) begin
               if (left == LEN_W'(1)) begin
                  cs_n <= 1'b1;
                  done <= 1'b1;
                  st   <= S_IDLE;
               end else begin
                  left <= left - 1'b1;
                  st   <= S_WAITW;
               end
            end
            S_GAP: begin
               if (gcnt == GW'(GAP_CYC - 1)) begin
                  cs_n     <= 1'b0;
                  sh_tx    <= SR_OPC;
                  sh_start <= 1'b1;
                  st       <= S_POLLOP;
               end else begin
                  gcnt <= gcnt + 1'b1;
               end
            end
            S_POLLOP: if (sh_done) begin
               sh_tx    <= '0;
               sh_start <= 1'b1;
               st       <= S_POLLRD;
            end
            S_POLLRD: if (sh_done) begin
               cs_n <= 1'b1;
               gcnt <= '0;
               if (poll_ok) begin
                  done <= 1'b1;
                  st   <= S_IDLE;
               end else if (pcnt + 1'b1 >= plim) begin
                  err  <= 1'b1;
                  done <= 1'b1;
                  st   <= S_IDLE;
               end else begin
                  pcnt <= pcnt + 1'b1;
                  st   <= S_GAP;
               end
            end
            default: st <= S_IDLE;
         endcase
      end
   end

   assign busy     = (st != S_IDLE);
   assign wr_ready = (st == S_WAITW);

   // R11: a chip-select release inside an operation lasts at least two cycles
   a_r11_cs_gap: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(cs_n) && busy) |=> cs_n);
   // R13: completion never overlaps an operation in progress
   a_r13_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
   // R12: the error flag only appears together with completion
   a_r12_err_done: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err) |-> done);
endmodule

// File: rtl/sflash_cmd_engine.sv
`timescale 1ns/1ps
module sflash_cmd_engine #(
   parameter int DIV_W   = 8,
   parameter int LEN_W   = 9,
   parameter int POLL_W  = 16,
   parameter int GAP_CYC = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DIV_W-1:0]  half_div,
   input  logic [POLL_W-1:0] poll_limit,
   input  logic              req_valid,
   input  logic [2:0]        req_cmd,
   input  logic [23:0]       req_addr,
   input  logic [LEN_W-1:0]  req_len,
   input  logic [7:0]        wr_data,
   input  logic              wr_valid,
   output logic              wr_ready,
   output logic [7:0]        rd_data,
   output logic              rd_valid,
   output logic              busy,
   output logic              done,
   output logic              err,
   output logic              sclk,
   output logic              cs_n,
   output logic              mosi,
   input  logic              miso
);
   if (LEN_W < 9) begin : g_bad_len
      $error("LEN_W must hold the value 256");
   end
   if (GAP_CYC < 2) begin : g_bad_gap
      $error("GAP_CYC must be at least 2");
   end
   if (DIV_W < 1 || POLL_W < 1) begin : g_bad_w
      $error("divider and poll widths must be positive");
   end

   logic       sh_start;
   logic [7:0] sh_tx;
   logic       sh_done;
   logic [7:0] sh_rx;

   sfe_seq #(
      .LEN_W  (LEN_W),
      .POLL_W (POLL_W),
      .GAP_CYC(GAP_CYC)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_cmd   (req_cmd),
      .req_addr  (req_addr),
      .req_len   (req_len),
      .poll_limit(poll_limit),
      .wr_data   (wr_data),
      .wr_valid  (wr_valid),
      .wr_ready  (wr_ready),
      .rd_data   (rd_data),
      .rd_valid  (rd_valid),
      .busy      (busy),
      .done      (done),
      .err       (err),
      .cs_n      (cs_n),
      .sh_start  (sh_start),
      .sh_tx     (sh_tx),
      .sh_done   (sh_done),
      .sh_rx     (sh_rx)
   );

   sfe_byte_shift #(
      .DIV_W(DIV_W)
   ) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .half_div (half_div),
      .start    (sh_start),
      .tx_byte  (sh_tx),
      .miso     (miso),
      .sclk     (sclk),
      .mosi     (mosi),
      .rx_byte  (sh_rx),
      .byte_done(sh_done)
   );

   // R2: the serial clock is parked low whenever the flash is deselected
   a_r2_sclk_parked: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> !sclk);
endmodule

// File: tb/tb_sflash_cmd_engine.sv
`timescale 1ns/1ps
module tb_sflash_cmd_engine;
   localparam int DIV_W = 8, LEN_W = 9, POLL_W = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic [DIV_W-1:0]  half_div = 8'd1;
   logic [POLL_W-1:0] poll_limit = 16'd16;
   logic              req_valid = 1'b0;
   logic [2:0]        req_cmd = '0;
   logic [23:0]       req_addr = '0;
   logic [LEN_W-1:0]  req_len = '0;
   logic [7:0]        wr_data;
   logic              wr_valid, wr_ready;
   logic [7:0]        rd_data;
   logic              rd_valid, busy, done, err, sclk, cs_n, mosi, miso;

   sflash_cmd_engine dut (
      .clk(clk), .rst_n(rst_n), .half_div(half_div), .poll_limit(poll_limit),
      .req_valid(req_valid), .req_cmd(req_cmd), .req_addr(req_addr), .req_len(req_len),
      .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
      .rd_data(rd_data), .rd_valid(rd_valid), .busy(busy), .done(done), .err(err),
      .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso)
   );

   int vectors = 0, miscompares = 0;

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // ---------------- behavioural flash ----------------
   logic [7:0]  fm_mem [0:63];
   logic [7:0]  fm_in = '0, fm_out = '0, fm_opc = '0, last_cmd = '0;
   logic [23:0] fm_addr = '0, last_addr = '0;
   int fm_bits = 0, fm_byte = 0, n_sr = 0, n_cmd = 0;
   int busy_cnt = 0, erase_len = 0, wel_lag = 0;
   bit fm_fresh = 0, wel = 0, wel_pend = 0;

   assign miso = fm_out[7];

   task automatic fm_handle(input logic [7:0] b);
      if (fm_byte == 0) begin
         fm_opc = b;
         if (b != 8'h05) last_cmd = b;
         else n_sr++;
         case (b)
            8'h9F:   fm_out = 8'hEF;
            8'h05:   fm_out = {6'b0, wel, (busy_cnt != 0)};
            default: fm_out = 8'h00;
         endcase
      end else if (fm_opc == 8'h9F) begin
         fm_out = (fm_byte == 1) ? 8'h40 : 8'h16;
      end else if (fm_opc == 8'h03 || fm_opc == 8'h02 || fm_opc == 8'h20) begin
         if (fm_byte <= 3) begin
            fm_addr = {fm_addr[15:0], b};
            last_addr = fm_addr;
            if (fm_byte == 3 && fm_opc == 8'h03) fm_out = fm_mem[fm_addr[5:0]];
         end else if (fm_opc == 8'h03) begin
            fm_addr = fm_addr + 24'd1;
            fm_out = fm_mem[fm_addr[5:0]];
         end else if (fm_opc == 8'h02) begin
            fm_mem[fm_addr[5:0]] = b;
            fm_addr = fm_addr + 24'd1;
         end
      end
   endtask

   always @(negedge cs_n) begin
      fm_bits = 0; fm_byte = 0; fm_out = '0; fm_fresh = 0; n_cmd++;
   end
   always @(posedge sclk) if (!cs_n) begin
      fm_in = {fm_in[6:0], mosi};
      fm_bits++;
      if (fm_bits == 8) begin
         fm_bits = 0;
         fm_handle(fm_in);
         fm_byte++;
         fm_fresh = 1;
      end
   end
   always @(negedge sclk) if (!cs_n) begin
      if (fm_fresh) fm_fresh = 0;
      else fm_out = {fm_out[6:0], 1'b0};
   end
   always @(posedge cs_n) begin
      if (fm_opc == 8'h05 && fm_byte >= 2) begin
         if (busy_cnt > 0) busy_cnt--;
         if (wel_lag > 0) wel_lag--;
         if (wel_lag == 0 && wel_pend) begin wel = 1; wel_pend = 0; end
      end else if (fm_opc == 8'h06) wel_pend = 1;
      else if (fm_opc == 8'hC7 || fm_opc == 8'h20) busy_cnt = erase_len;
   end

   // ---------------- host side helpers ----------------
   logic [7:0] wbuf [0:7];
   int wr_ptr = 0, wr_n = 0;
   bit wr_hold = 0;
   assign wr_valid = (wr_ptr < wr_n) && !wr_hold;
   assign wr_data  = wbuf[wr_ptr[2:0]];
   always @(posedge clk) if (wr_valid && wr_ready) wr_ptr <= wr_ptr + 1;

   logic [7:0] rbuf [0:15];
   int rn = 0, hi_run = 0, sclk_hi_max = 0, cs_hi = 0, min_gap = 1000;
   always @(negedge clk) begin
      if (rd_valid) begin rbuf[rn[3:0]] = rd_data; rn++; end
      if (sclk) hi_run++;
      else begin
         if (hi_run > sclk_hi_max) sclk_hi_max = hi_run;
         hi_run = 0;
      end
      if (cs_n) cs_hi++;
      else begin
         if (cs_hi > 0 && busy && cs_hi < min_gap) min_gap = cs_hi;
         cs_hi = 0;
      end
   end

   logic last_err, last_busy;
   task automatic run_cmd(input logic [2:0] c, input logic [23:0] a, input logic [LEN_W-1:0] n);
      @(negedge clk);
      rn = 0; sclk_hi_max = 0;
      req_cmd = c; req_addr = a; req_len = n; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      while (!done) @(negedge clk);
      last_err = err; last_busy = busy;
      #1;
   endtask

   // ---------------- scenarios ----------------
   task automatic t_reset;
      check("R1 cs_n", 32'(cs_n), 1);
      check("R1 sclk", 32'(sclk), 0);
      check("R1 busy/done/err", {29'd0, busy, done, err}, 0);
   endtask

   task automatic t_read_id;
      run_cmd(3'd0, 24'd0, '0);
      check("R3 byte count", rn, 3);
      check("R3 id bytes", {8'd0, rbuf[0], rbuf[1], rbuf[2]}, 32'h00EF4016);
      check("R3 opcode", 32'(last_cmd), 32'h9F);
      check("R13 done ends busy", {30'd0, last_busy, last_err}, 0);
   endtask

   task automatic t_wren;
      int s0;
      s0 = n_sr; wel_lag = 2; min_gap = 1000;
      run_cmd(3'd2, 24'd0, '0);
      check("R5 opcode", 32'(last_cmd), 32'h06);
      check("R5 polls until write-enabled", n_sr - s0, 3);
      check("R5 no error", 32'(last_err), 0);
      check("R11 gap before poll", min_gap, 2);
   endtask

   task automatic t_rdsr;
      run_cmd(3'd1, 24'd0, '0);
      check("R4 one status byte", rn, 1);
      check("R4 status value", 32'(rbuf[0]), 32'h02);
   endtask

   task automatic t_sector;
      int s0;
      s0 = n_sr; erase_len = 4;
      run_cmd(3'd4, 24'h12345F, '0);
      check("R7 opcode", 32'(last_cmd), 32'h20);
      check("R7 address order", 32'(last_addr), 32'h12345F);
      check("R7 polls until not busy", n_sr - s0, 5);
      check("R7 no error", 32'(last_err), 0);
   endtask

   task automatic t_chip;
      int s0;
      s0 = n_sr; erase_len = 1;
      run_cmd(3'd3, 24'd0, '0);
      check("R6 opcode", 32'(last_cmd), 32'hC7);
      check("R6 polls", n_sr - s0, 2);
      check("R6 no error", 32'(last_err), 0);
   endtask

   task automatic t_timeout;
      int s0;
      s0 = n_sr; erase_len = 100; poll_limit = 16'd3;
      run_cmd(3'd3, 24'd0, '0);
      check("R12 error on timeout", 32'(last_err), 1);
      check("R12 poll count", n_sr - s0, 3);
      check("R13 idle after timeout", 32'(last_busy), 0);
      busy_cnt = 0; poll_limit = 16'd16;
   endtask

   task automatic t_prog;
      wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33; wbuf[3] = 8'hC4;
      wr_hold = 1; wr_ptr = 0; wr_n = 4;
      fork
         run_cmd(3'd6, 24'h00A010, 9'd4);
         begin
            repeat (150) @(negedge clk);
            check("R9 cs held while starved", {31'd0, cs_n}, 0);
            check("R9 no byte taken early", wr_ptr, 0);
            wr_hold = 0;
         end
      join
      check("R9 opcode", 32'(last_cmd), 32'h02);
      check("R9 address", 32'(last_addr), 32'h00A010);
      check("R9 bytes stored", {fm_mem[16], fm_mem[17], fm_mem[18], fm_mem[19]}, 32'h112233C4);
      check("R9 all bytes taken", wr_ptr, 4);
      wr_n = 0; wr_ptr = 0;
   endtask

   task automatic t_read;
      run_cmd(3'd5, 24'h00A010, 9'd4);
      check("R8 opcode", 32'(last_cmd), 32'h03);
      check("R8 count", rn, 4);
      check("R8 data", {rbuf[0], rbuf[1], rbuf[2], rbuf[3]}, 32'h112233C4);
   endtask

   task automatic t_reject;
      int c0;
      c0 = n_cmd;
      run_cmd(3'd6, 24'd0, 9'd0);
      check("R10 zero length error", 32'(last_err), 1);
      run_cmd(3'd6, 24'd0, 9'd256);
      check("R10 256 length error", 32'(last_err), 1);
      run_cmd(3'd7, 24'd0, 9'd1);
      check("R10 bad code error", 32'(last_err), 1);
      check("R10 no chip select", n_cmd - c0, 0);
   endtask

   task automatic t_divider;
      half_div = 8'd3;
      run_cmd(3'd1, 24'd0, '0);
      check("R2 high phase div 3", sclk_hi_max, 3);
      check("R2 data at div 3", 32'(rbuf[0]), 32'h02);
      half_div = 8'd0;
      run_cmd(3'd1, 24'd0, '0);
      check("R2 high phase div 0", sclk_hi_max, 1);
      half_div = 8'd1;
   endtask

   initial begin
      for (int i = 0; i < 64; i++) fm_mem[i] = 8'(i) ^ 8'hA5;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      t_reset();
      t_read_id();
      t_wren();
      t_rdsr();
      t_sector();
      t_chip();
      t_timeout();
      t_prog();
      t_read();
      t_reject();
      t_divider();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      miscompares++;
      $display("FAIL R13 watchdog: actual still running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule